// File: doc/BRIEF.md
# Five-Stage Pipelined Load/Store Core

This block is a 32-bit in-order processor core built as five stages: instruction fetch, decode with register read, execute or address calculation, memory access, and register write-back. Four pipeline registers separate the stages. Each instruction carries its operands, its destination register number and its control bits with it as it moves down. Control is decoded once, in decode, into three groups: execute, memory and write-back. Each stage takes its own group, and the groups that remain go on to the next register.

The core runs five instructions: word load, word store, and register-to-register add, subtract, AND and OR. Instruction memory and data memory are internal word arrays. A loading port fills either memory while reset is held. Two combinational debug ports read any register and any data word. There is no hazard detection, no forwarding and no branching. Software must therefore place two no-op words between an instruction and any later instruction that reads its result. The register file passes a value written in write-back straight to a decode read of the same register, which is what makes a gap of two enough.

Top module: `pipe5_core`

## Requirements
- R1: When reset is released, the PC is 0, every register reads 0, and no register or memory write takes place while the pipeline fills.
- R2: R-type words (opcode 0) with funct 0x20, 0x22, 0x24 or 0x25 write rs+rt, rs-rt, rs AND rt, or rs OR rt into rd (rs in bits 25:21, rt in 20:16, rd in 15:11, funct in 5:0).
- R3: Opcode 0x23 (load) writes into rt the data word at word index bits [2 +: MEM_AW] of rs plus the immediate in bits 15:0.
- R4: Opcode 0x2B (store) writes rt to data memory at the effective address worked out as for a load, and changes no register.
- R5: Register 0 always reads as 0. A write to it has no effect.
- R6: When write-back writes a register in the same cycle that decode reads it, decode gets the new value. An instruction that comes two no-ops after the producer of its operand therefore sees that result.
- R7: The result of the instruction at word index k is visible in the register file after clock edge k+5, counting from the first edge after reset is released, and not after edge k+4. One instruction completes each cycle.
- R8: An all-zero word, any opcode other than 0, 0x23 and 0x2B, and an R-type word with any other funct change no register and no memory word.
- R9: The 16-bit immediate is sign-extended, so a negative displacement addresses below the base register.
- R10: While progWe is high, progData is written to instruction memory (progSel=0) or data memory (progSel=1) at word index progAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| progWe | input | 1 | Write strobe of the loading port |
| progSel | input | 1 | Target: 0 instruction memory, 1 data memory |
| progAddr | input | MEM_AW | Word index of the loading write |
| progData | input | 32 | Word to load |
| dbgRegSel | input | 5 | Register number to observe |
| dbgRegData | output | 32 | Value of the selected register |
| dbgMemAddr | input | MEM_AW | Data word index to observe |
| dbgMemData | output | 32 | Value of the selected data word |

## Verification
The bench builds the core with the default MEM_AW of 6, so both memories hold 64 words. That is room for random programs of up to 48 words, each followed by the run time it needs to drain, before the PC wraps. With 64 data words, random load and store offsets collide often, so stores followed by loads of the same word do occur. Directed programs cover cycle-exact latency, the gap of exactly two no-ops that needs the write-through read, negative displacements, writes to register 0 and words that must do nothing. Random programs are checked word by word against a sequential model.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;
  localparam logic [5:0] FN_AND   = 6'h24;
  localparam logic [5:0] FN_OR    = 6'h25;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

  typedef struct packed {
    alu_op_e aluOp;
    logic    useImm;
  } ex_ctrl_t;

  typedef struct packed {
    logic memRead;
    logic memWrite;
  } mem_ctrl_t;

  typedef struct packed {
    logic regWrite;
    logic memToReg;
  } wb_ctrl_t;

  typedef struct packed {
    ex_ctrl_t  ex;
    mem_ctrl_t mem;
    wb_ctrl_t  wb;
    logic      destRt;
  } ctrl_t;
endpackage

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.wb.regWrite = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.ex.aluOp = ALU_ADD;
          FN_SUB:  ctrl.ex.aluOp = ALU_SUB;
          FN_AND:  ctrl.ex.aluOp = ALU_AND;
          FN_OR:   ctrl.ex.aluOp = ALU_OR;
          default: ctrl.wb.regWrite = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.ex.useImm   = 1'b1;
        ctrl.mem.memRead = 1'b1;
        ctrl.wb.regWrite = 1'b1;
        ctrl.wb.memToReg = 1'b1;
        ctrl.destRt      = 1'b1;
      end
      OP_STORE: begin
        ctrl.ex.useImm    = 1'b1;
        ctrl.mem.memWrite = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/pipe5_datapath.sv
module pipe5_datapath
  import pipe5_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              progWe,
  input  logic              progSel,
  input  logic [MEM_AW-1:0] progAddr,
  input  logic [31:0]       progData,
  input  ctrl_t             decCtrl,
  output logic [5:0]        decOpcode,
  output logic [5:0]        decFunct,
  input  logic [4:0]        dbgRegSel,
  output logic [31:0]       dbgRegData,
  input  logic [MEM_AW-1:0] dbgMemAddr,
  output logic [31:0]       dbgMemData,
  output logic [31:0]       obsPc,
  output logic              obsRfWe,
  output logic              obsExMemWr,
  output logic [4:0]        obsExMemDest,
  output logic [4:0]        obsMemWbDest
);
  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int NUM_REGS  = 32;

  typedef struct packed {
    ex_ctrl_t    ex;
    mem_ctrl_t   mem;
    wb_ctrl_t    wb;
    logic [31:0] rsVal;
    logic [31:0] rtVal;
    logic [31:0] imm;
    logic [4:0]  dest;
  } id_ex_t;

  typedef struct packed {
    mem_ctrl_t   mem;
    wb_ctrl_t    wb;
    logic [31:0] aluRes;
    logic [31:0] storeVal;
    logic [4:0]  dest;
  } ex_mem_t;

  typedef struct packed {
    wb_ctrl_t    wb;
    logic [31:0] memData;
    logic [31:0] aluRes;
    logic [4:0]  dest;
  } mem_wb_t;

  logic [31:0] imem [MEM_DEPTH];
  logic [31:0] dmem [MEM_DEPTH];
  logic [31:0] rf   [NUM_REGS];

  logic [31:0] pc;
  logic [31:0] ifIdInstr;
  id_ex_t      idEx;
  ex_mem_t     exMem;
  mem_wb_t     memWb;

  // fetch
  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      ifIdInstr <= '0;
    end else begin
      ifIdInstr <= imem[pc[2 +: MEM_AW]];
      pc        <= pc + 32'd4;
    end
  end

  always_ff @(posedge clk) begin
    if (progWe && !progSel) imem[progAddr] <= progData;
  end

  // decode and register read with write-through
  logic [4:0]  rsIdx, rtIdx, rdIdx;
  logic [31:0] wbData, rsRead, rtRead;
  logic        wbWe;

  assign decOpcode = ifIdInstr[31:26];
  assign decFunct  = ifIdInstr[5:0];
  assign rsIdx     = ifIdInstr[25:21];
  assign rtIdx     = ifIdInstr[20:16];
  assign rdIdx     = ifIdInstr[15:11];
  assign wbWe      = memWb.wb.regWrite && (memWb.dest != 5'd0);
  assign wbData    = memWb.wb.memToReg ? memWb.memData : memWb.aluRes;

  function automatic logic [31:0] readReg(input logic [4:0] idx, input logic we,
                                          input logic [4:0] wIdx, input logic [31:0] wData,
                                          input logic [31:0] stored);
    if (idx == 5'd0)             return '0;
    else if (we && wIdx == idx)  return wData;
    else                         return stored;
  endfunction

  assign rsRead = readReg(rsIdx, wbWe, memWb.dest, wbData, rf[rsIdx]);
  assign rtRead = readReg(rtIdx, wbWe, memWb.dest, wbData, rf[rtIdx]);

  always_ff @(posedge clk) begin
    if (rst) begin
      idEx <= '0;
    end else begin
      idEx.ex    <= decCtrl.ex;
      idEx.mem   <= decCtrl.mem;
      idEx.wb    <= decCtrl.wb;
      idEx.rsVal <= rsRead;
      idEx.rtVal <= rtRead;
      idEx.imm   <= {{16{ifIdInstr[15]}}, ifIdInstr[15:0]};
      idEx.dest  <= decCtrl.destRt ? rtIdx : rdIdx;
    end
  end

  // execute
  logic [31:0] aluB, aluOut;
  assign aluB = idEx.ex.useImm ? idEx.imm : idEx.rtVal;

  always_comb begin
    unique case (idEx.ex.aluOp)
      ALU_ADD: aluOut = idEx.rsVal + aluB;
      ALU_SUB: aluOut = idEx.rsVal - aluB;
      ALU_AND: aluOut = idEx.rsVal & aluB;
      default: aluOut = idEx.rsVal | aluB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exMem <= '0;
    end else begin
      exMem.mem      <= idEx.mem;
      exMem.wb       <= idEx.wb;
      exMem.aluRes   <= aluOut;
      exMem.storeVal <= idEx.rtVal;
      exMem.dest     <= idEx.dest;
    end
  end

  // memory access
  logic [MEM_AW-1:0] dIdx;
  assign dIdx = exMem.aluRes[2 +: MEM_AW];

  always_ff @(posedge clk) begin
    if (progWe && progSel)      dmem[progAddr] <= progData;
    else if (exMem.mem.memWrite) dmem[dIdx]    <= exMem.storeVal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memWb <= '0;
    end else begin
      memWb.wb      <= exMem.wb;
      memWb.memData <= exMem.mem.memRead ? dmem[dIdx] : '0;
      memWb.aluRes  <= exMem.aluRes;
      memWb.dest    <= exMem.dest;
    end
  end

  // write-back
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) rf[i] <= '0;
    end else if (wbWe) begin
      rf[memWb.dest] <= wbData;
    end
  end

  assign dbgRegData   = (dbgRegSel == 5'd0) ? '0 : rf[dbgRegSel];
  assign dbgMemData   = dmem[dbgMemAddr];
  assign obsPc        = pc;
  assign obsRfWe      = memWb.wb.regWrite;
  assign obsExMemWr   = exMem.mem.memWrite;
  assign obsExMemDest = exMem.dest;
  assign obsMemWbDest = memWb.dest;
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              progWe,
  input  logic              progSel,
  input  logic [MEM_AW-1:0] progAddr,
  input  logic [31:0]       progData,
  input  logic [4:0]        dbgRegSel,
  output logic [31:0]       dbgRegData,
  input  logic [MEM_AW-1:0] dbgMemAddr,
  output logic [31:0]       dbgMemData
);
  ctrl_t       decCtrl;
  logic [5:0]  decOpcode, decFunct;
  logic [31:0] obsPc;
  logic        obsRfWe, obsExMemWr;
  logic [4:0]  obsExMemDest, obsMemWbDest;

  pipe5_ctrl u_ctrl (
    .opcode(decOpcode),
    .funct (decFunct),
    .ctrl  (decCtrl)
  );

  pipe5_datapath #(.MEM_AW(MEM_AW)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .progWe      (progWe),
    .progSel     (progSel),
    .progAddr    (progAddr),
    .progData    (progData),
    .decCtrl     (decCtrl),
    .decOpcode   (decOpcode),
    .decFunct    (decFunct),
    .dbgRegSel   (dbgRegSel),
    .dbgRegData  (dbgRegData),
    .dbgMemAddr  (dbgMemAddr),
    .dbgMemData  (dbgMemData),
    .obsPc       (obsPc),
    .obsRfWe     (obsRfWe),
    .obsExMemWr  (obsExMemWr),
    .obsExMemDest(obsExMemDest),
    .obsMemWbDest(obsMemWbDest)
  );
endmodule

// File: rtl/pipe5_checker.sv
module pipe5_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] obsPc,
  input logic        obsRfWe,
  input logic        obsExMemWr,
  input logic [4:0]  obsExMemDest,
  input logic [4:0]  obsMemWbDest,
  input logic [4:0]  dbgRegSel,
  input logic [31:0] dbgRegData
);
  logic [2:0] upCycles;

  always_ff @(posedge clk) begin
    if (rst)                 upCycles <= '0;
    else if (upCycles != 7)  upCycles <= upCycles + 3'd1;
  end

  assert_no_fill_write_R1: assert property (@(posedge clk) disable iff (rst)
    (upCycles < 3'd4) |-> !obsRfWe);

  assert_pc_advance_R7: assert property (@(posedge clk) disable iff (rst)
    (upCycles >= 3'd1) |-> (obsPc == $past(obsPc) + 32'd4));

  assert_dest_travels_R7: assert property (@(posedge clk) disable iff (rst)
    (upCycles >= 3'd1) |-> (obsMemWbDest == $past(obsExMemDest)));

  assert_store_no_wb_R4: assert property (@(posedge clk) disable iff (rst)
    obsExMemWr |=> !obsRfWe);

  assert_zero_reg_R5: assert property (@(posedge clk) disable iff (rst)
    (dbgRegSel == 5'd0) |-> (dbgRegData == 32'd0));
endmodule

bind pipe5_core pipe5_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .obsPc       (obsPc),
  .obsRfWe     (obsRfWe),
  .obsExMemWr  (obsExMemWr),
  .obsExMemDest(obsExMemDest),
  .obsMemWbDest(obsMemWbDest),
  .dbgRegSel   (dbgRegSel),
  .dbgRegData  (dbgRegData)
);

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;
  localparam int MEM_AW = 6;
  localparam int DEPTH  = 1 << MEM_AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              progWe = 1'b0;
  logic              progSel = 1'b0;
  logic [MEM_AW-1:0] progAddr = '0;
  logic [31:0]       progData = '0;
  logic [4:0]        dbgRegSel = '0;
  logic [31:0]       dbgRegData;
  logic [MEM_AW-1:0] dbgMemAddr = '0;
  logic [31:0]       dbgMemData;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] prog  [DEPTH];
  logic [31:0] dinit [DEPTH];
  logic [31:0] mRegs [32];
  logic [31:0] mMem  [DEPTH];

  always #2 clk = ~clk;

  pipe5_core #(.MEM_AW(MEM_AW)) u_pipe5_core (
    .clk(clk), .rst(rst), .progWe(progWe), .progSel(progSel),
    .progAddr(progAddr), .progData(progData), .dbgRegSel(dbgRegSel),
    .dbgRegData(dbgRegData), .dbgMemAddr(dbgMemAddr), .dbgMemData(dbgMemData)
  );

  function automatic logic [31:0] rtype(input logic [5:0] fn, input logic [4:0] rd,
                                        input logic [4:0] rs, input logic [4:0] rt);
    return {6'h00, rs, rt, rd, 5'h00, fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < DEPTH; i++) begin
      prog[i]  = '0;
      dinit[i] = '0;
    end
  endtask

  // hold reset, fill both memories, release reset on a falling edge
  task automatic loadAndRelease();
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      progWe = 1'b1; progSel = 1'b0; progAddr = i[MEM_AW-1:0]; progData = prog[i];
      @(negedge clk);
    end
    for (int i = 0; i < DEPTH; i++) begin
      progWe = 1'b1; progSel = 1'b1; progAddr = i[MEM_AW-1:0]; progData = dinit[i];
      @(negedge clk);
    end
    progWe = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic readReg(input int r, output logic [31:0] v);
    dbgRegSel = r[4:0];
    #0.1;
    v = dbgRegData;
  endtask

  task automatic readMem(input int a, output logic [31:0] v);
    dbgMemAddr = a[MEM_AW-1:0];
    #0.1;
    v = dbgMemData;
  endtask

  task automatic runModel(input int len);
    for (int i = 0; i < 32; i++) mRegs[i] = '0;
    for (int i = 0; i < DEPTH; i++) mMem[i] = dinit[i];
    for (int k = 0; k < len; k++) begin
      logic [31:0] w, addr, res;
      logic [4:0]  rs, rt, rd;
      logic        wr;
      w = prog[k];
      rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
      addr = mRegs[rs] + {{16{w[15]}}, w[15:0]};
      wr = 1'b0; res = '0;
      if (w[31:26] == 6'h00) begin
        wr = 1'b1;
        case (w[5:0])
          6'h20: res = mRegs[rs] + mRegs[rt];
          6'h22: res = mRegs[rs] - mRegs[rt];
          6'h24: res = mRegs[rs] & mRegs[rt];
          6'h25: res = mRegs[rs] | mRegs[rt];
          default: wr = 1'b0;
        endcase
        if (wr && rd != 0) mRegs[rd] = res;
      end else if (w[31:26] == 6'h23) begin
        if (rt != 0) mRegs[rt] = mMem[addr[2 +: MEM_AW]];
      end else if (w[31:26] == 6'h2B) begin
        mMem[addr[2 +: MEM_AW]] = mRegs[rt];
      end
    end
  endtask

  task automatic compareAll(input string req);
    logic [31:0] v;
    for (int r = 0; r < 32; r++) begin
      readReg(r, v);
      check(req, v, mRegs[r]);
    end
    for (int a = 0; a < DEPTH; a++) begin
      readMem(a, v);
      check(req, v, mMem[a]);
    end
  endtask

  function automatic logic [31:0] randInstr();
    int kind;
    logic [4:0] a, b, c;
    logic [15:0] off;
    kind = $urandom_range(0, 9);
    a = 5'($urandom_range(0, 31));
    b = 5'($urandom_range(0, 31));
    c = 5'($urandom_range(0, 31));
    off = 16'($urandom_range(0, DEPTH - 1) * 4);
    case (kind)
      0, 1: return itype(6'h23, 5'd0, a, off);
      2:    return itype(6'h2B, 5'd0, a, off);
      9: begin
        if ($urandom_range(0, 1) == 0) return {6'h3F, 26'($urandom())};
        else return rtype(6'h21, a, b, c);
      end
      default: begin
        case ($urandom_range(0, 3))
          0: return rtype(6'h20, a, b, c);
          1: return rtype(6'h22, a, b, c);
          2: return rtype(6'h24, a, b, c);
          default: return rtype(6'h25, a, b, c);
        endcase
      end
    endcase
  endfunction

  initial begin
    logic [31:0] v;
    void'($urandom(32'd77));

    // directed 1: reset state, loading port, exact latency and throughput
    clearProg();
    prog[0] = itype(6'h23, 5'd0, 5'd1, 16'd0);
    prog[1] = itype(6'h23, 5'd0, 5'd2, 16'd4);
    dinit[0] = 32'h0000_1234;
    dinit[1] = 32'h0000_55AA;
    loadAndRelease();
    readMem(0, v);  check("R10 data preload", v, 32'h0000_1234);
    readReg(1, v);  check("R1 reset r1", v, 32'd0);
    readReg(31, v); check("R1 reset r31", v, 32'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    readReg(1, v);  check("R7 not before edge 5", v, 32'd0);
    @(posedge clk); @(negedge clk);
    readReg(1, v);  check("R7 at edge 5", v, 32'h0000_1234);
    readReg(2, v);  check("R7 second not yet", v, 32'd0);
    @(posedge clk); @(negedge clk);
    readReg(2, v);  check("R7 throughput edge 6", v, 32'h0000_55AA);

    // directed 2: r0, store, negative offset, no-op words, write-through read
    clearProg();
    dinit[0] = 32'd7;
    dinit[2] = 32'd16;
    dinit[3] = 32'h0000_ABCD;
    prog[0]  = itype(6'h23, 5'd0, 5'd1, 16'd0);
    prog[3]  = rtype(6'h20, 5'd0, 5'd1, 5'd1);
    prog[4]  = itype(6'h23, 5'd0, 5'd4, 16'd8);
    prog[7]  = itype(6'h23, 5'd4, 5'd3, 16'hFFFC);
    prog[10] = itype(6'h2B, 5'd4, 5'd1, 16'hFFF8);
    prog[11] = 32'hFC00_0000 | (5'd5 << 16);
    prog[12] = rtype(6'h21, 5'd5, 5'd1, 5'd3);
    prog[13] = rtype(6'h20, 5'd6, 5'd1, 5'd3);
    prog[16] = rtype(6'h22, 5'd7, 5'd6, 5'd1);
    loadAndRelease();
    repeat (40) @(posedge clk);
    @(negedge clk);
    readReg(0, v); check("R5 write to r0 ignored", v, 32'd0);
    readReg(3, v); check("R9 negative displacement", v, 32'h0000_ABCD);
    readMem(2, v); check("R4 store data", v, 32'd7);
    readReg(5, v); check("R8 unknown op and funct", v, 32'd0);
    readReg(6, v); check("R2 add", v, 32'h0000_ABD4);
    readReg(7, v); check("R6 two-gap write-through", v, 32'h0000_ABCD);
    runModel(20);
    compareAll("R2 R4 R8 directed state");

    // random programs: each instruction followed by two no-ops
    for (int round = 0; round < 6; round++) begin
      clearProg();
      for (int i = 0; i < DEPTH; i++) dinit[i] = $urandom();
      for (int k = 0; k < 16; k++) prog[3 * k] = randInstr();
      loadAndRelease();
      repeat (58) @(posedge clk);
      @(negedge clk);
      runModel(48);
      compareAll("R2 R3 R4 R6 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule